// File: doc/BRIEF.md
# Dual-Channel Serial ADC Frame Sequencer

This block runs a serial successive-approximation converter that has a two-input multiplexer in front of it and a single level pin that picks the input. It drives the active-low chip select, the serial clock and the input-select level, and it shifts in each conversion result. Every returned word is tagged with the input it was sampled from. The block scans the two inputs in turn, or it holds one input chosen by a configuration pin.

The converter samples its input on the falling edge of chip select. That sample is the input chosen during the previous frame, so the select level driven in frame k belongs to the word that comes back in frame k+1. The conversion ends on a rising serial clock edge fixed by the resolution: edge 14 for 12 bits, edge 11 for 10 bits and edge 9 for 8 bits. The select level may change only in one slot, after the first rising edge of a frame and before the second. The sequencer moves it on the falling edge inside that slot. When `start` is high, frames follow one another with a fixed chip-select gap. When `start` is cleared, the frame in progress finishes and no new one begins.

Top module: `adc_dual_seq`

## Requirements
- R1: While reset is asserted and right after it: `cs_n`=1, `sclk`=0, `ch_sel`=0, `out_valid`=0.
- R2: `sclk` rests low whenever `cs_n` is high. Inside a frame, each high phase and each low phase lasts SCLK_DIV/2 system cycles. The first rising edge comes SCLK_DIV/2 cycles after `cs_n` falls.
- R3: A frame has exactly EDGES rising `sclk` edges (14, 11 or 9 for RES_BITS 12, 10 or 8). `cs_n` rises in the same cycle as the falling edge that follows the last rising edge.
- R4: `ch_sel` changes only at the first falling `sclk` edge of a frame, that is, between rising edges 1 and 2, with `cs_n` low.
- R5: When `alt_mode`=1, the level set at that falling edge is 0 in the first frame after reset. In every later frame it is the inverse of the level the previous frame set.
- R6: When `alt_mode`=0, the level set at that falling edge equals `fix_ch`.
- R7: Result bits are sampled on rising edges EDGES-RES_BITS+1 through EDGES, MSB first. They appear right-aligned in `out_data`, and the upper WORD_W-RES_BITS bits are zero.
- R8: `out_ch` equals the `ch_sel` level present when `cs_n` fell for the frame that returned the word. This is the level set in the previous frame.
- R9: The first frame after reset gives no `out_valid`. Every later frame gives exactly one.
- R10: `out_valid` is high for a single cycle, in the cycle where `cs_n` rises. `out_data` and `out_ch` hold the result in that cycle.
- R11: Between frames, with `start` held high, `cs_n` stays high for exactly GAP_CYCLES cycles. No frame starts while `start` is low.
- R12: If `start` is cleared during a frame, that frame runs to its end and then `cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Enables continuous framing |
| alt_mode | input | 1 | 1: alternate inputs; 0: hold `fix_ch` |
| fix_ch | input | 1 | Input chosen when alternation is off (0 = pair 0, 1 = pair 1) |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, low at rest |
| ch_sel | output | 1 | Multiplexer select level (0 = pair 0, 1 = pair 1) |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | WORD_W | Right-aligned conversion result |
| out_ch | output | 1 | Input the result was sampled from |

## Verification
Every output of this block changes on the system clock edge that also moves `sclk` or `cs_n`. The bench's converter model and its checker therefore run on the falling system clock edge. In that half cycle the edge that caused a change is already visible and the next edge has not yet happened. The select level is due at the half cycle in which the first falling `sclk` edge appears. The result, its tag and the strobe are due at the half cycle in which `cs_n` is seen high again, and they are checked only there. Serial-clock phase lengths and the chip-select gap are measured by counting half-cycle samples from the last observed edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [0:0] {
      ST_GAP   = 1'b0,
      ST_FRAME = 1'b1
   } seq_state_t;

   // rising serial-clock edge on which a conversion finishes
   function automatic int unsigned conv_edge_count(input int unsigned res);
      case (res)
         12:      return 14;
         10:      return 11;
         8:       return 9;
         default: return res + 2;
      endcase
   endfunction

   function automatic int unsigned bits_for(input int unsigned value);
      return (value > 1) ? $clog2(value + 1) : 1;
   endfunction

endpackage

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk #(
   parameter int unsigned SCLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_now,
   output logic fall_now
);
   localparam int unsigned HALF = SCLK_DIV / 2;
   localparam int unsigned HW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic edge_due;

   generate
      if (HALF == 1) begin : g_every_cycle
         assign edge_due = run;
      end else begin : g_counted
         logic [HW-1:0] hcnt;
         assign edge_due = run && (hcnt == HW'(HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 hcnt <= '0;
            else if (!run || edge_due)  hcnt <= '0;
            else                        hcnt <= hcnt + 1'b1;
         end
      end
   endgenerate

   assign rise_now = edge_due && !sclk;
   assign fall_now = edge_due &&  sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sclk <= 1'b0;
      else if (!run)     sclk <= 1'b0;
      else if (edge_due) sclk <= ~sclk;
   end

   AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sclk); // R2

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
   parameter int unsigned RES_BITS = 12,
   parameter int unsigned EDGES    = 14,
   parameter int unsigned WORD_W   = 12,
   parameter int unsigned CW       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              rise_now,
   input  logic [CW-1:0]     rise_cnt,
   input  logic              miso,
   output logic [WORD_W-1:0] word
);
   localparam int unsigned LEAD = EDGES - RES_BITS;

   logic [RES_BITS-1:0] sr;
   logic                take;

   // rise_cnt holds the edges already made; the edge now due is rise_cnt+1
   assign take = rise_now && (rise_cnt >= CW'(LEAD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sr <= '0;
      else if (frame_start) sr <= '0;
      else if (take)        sr <= {sr[RES_BITS-2:0], miso};
   end

   generate
      if (WORD_W == RES_BITS) begin : g_full
         assign word = sr;
      end else begin : g_pad
         assign word = {{(WORD_W - RES_BITS){1'b0}}, sr};
      end
   endgenerate

   AST_TAKE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (rise_cnt < CW'(EDGES))); // R7

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic win,
   input  logic frame_start,
   input  logic alt_mode,
   input  logic fix_ch,
   output logic ch_sel,
   output logic tag
);
   logic seen_q;
   logic next_ch;

   always_comb begin
      if (alt_mode) next_ch = seen_q ? ~ch_sel : 1'b0;
      else          next_ch = fix_ch;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_sel <= 1'b0;
         seen_q <= 1'b0;
      end else if (win) begin
         ch_sel <= next_ch;
         seen_q <= 1'b1;
      end
   end

   // level in force at the sampling instant travels with the frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tag <= 1'b0;
      else if (frame_start) tag <= ch_sel;
   end

   AST_FIXED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (win && !alt_mode) |=> (ch_sel == $past(fix_ch))); // R6
   AST_ALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (win && alt_mode && !seen_q) |=> !ch_sel); // R5

endmodule

// File: rtl/adc_dual_seq.sv
module adc_dual_seq
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_BITS   = 12,
   parameter int unsigned SCLK_DIV   = 4,
   parameter int unsigned GAP_CYCLES = 3,
   parameter int unsigned WORD_W     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              alt_mode,
   input  logic              fix_ch,
   input  logic              miso,
   output logic              cs_n,
   output logic              sclk,
   output logic              ch_sel,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_ch
);
   localparam int unsigned EDGES = conv_edge_count(RES_BITS);
   localparam int unsigned CW    = bits_for(EDGES);
   localparam int unsigned GW    = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

   generate
      if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
         $error("RES_BITS must be 8, 10 or 12");
      end
      if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_div
         $error("SCLK_DIV must be even and at least 2");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 1");
      end
      if (WORD_W < RES_BITS) begin : g_bad_word
         $error("WORD_W must hold RES_BITS");
      end
   endgenerate

   seq_state_t     state;
   logic [GW-1:0]  gap_cnt;
   logic [CW-1:0]  rise_cnt;
   logic           had_frame;
   logic           gap_done, frame_start, frame_end, win;
   logic           rise_now, fall_now, run;
   logic           tag;
   logic [WORD_W-1:0] word;

   assign run         = (state == ST_FRAME);
   assign gap_done    = (gap_cnt == GW'(GAP_CYCLES - 1));
   assign frame_start = (state == ST_GAP) && gap_done && start;
   assign frame_end   = run && fall_now && (rise_cnt == CW'(EDGES));
   assign win         = run && fall_now && (rise_cnt == CW'(1));

   adc_seq_sclk #(.SCLK_DIV(SCLK_DIV)) i_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sclk     (sclk),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   adc_seq_capture #(
      .RES_BITS (RES_BITS),
      .EDGES    (EDGES),
      .WORD_W   (WORD_W),
      .CW       (CW)
   ) i_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .rise_now    (rise_now),
      .rise_cnt    (rise_cnt),
      .miso        (miso),
      .word        (word)
   );

   adc_seq_chan i_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .win         (win),
      .frame_start (frame_start),
      .alt_mode    (alt_mode),
      .fix_ch      (fix_ch),
      .ch_sel      (ch_sel),
      .tag         (tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_GAP;
         cs_n  <= 1'b1;
      end else if (frame_start) begin
         state <= ST_FRAME;
         cs_n  <= 1'b0;
      end else if (frame_end) begin
         state <= ST_GAP;
         cs_n  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      gap_cnt <= '0;
      else if (run)                    gap_cnt <= '0;
      else if (!gap_done)              gap_cnt <= gap_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rise_cnt <= '0;
      else if (frame_start) rise_cnt <= '0;
      else if (rise_now)    rise_cnt <= rise_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         had_frame <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ch    <= 1'b0;
      end else begin
         out_valid <= frame_end && had_frame;
         if (frame_end) begin
            had_frame <= 1'b1;
            out_data  <= word;
            out_ch    <= tag;
         end
      end
   end

   AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk); // R2
   AST_RISE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      rise_cnt <= CW'(EDGES)); // R3
   AST_CS_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (rise_cnt == CW'(EDGES) && !sclk)); // R3
   AST_CHSEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_sel) |-> (!cs_n && !sclk && $past(sclk) && rise_cnt == CW'(1))); // R4
   AST_DATA_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data >> RES_BITS) == '0)); // R7
   AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $rose(cs_n)); // R10
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R10

endmodule

// File: tb/test_adc_dual_seq.sv
module test_adc_dual_seq;
   localparam int RES  = 12;
   localparam int DIV  = 4;
   localparam int GAP  = 3;
   localparam int W    = 12;

   function automatic int edges_for(input int r);
      if (r == 12) return 14;
      if (r == 10) return 11;
      return 9;
   endfunction

   localparam int N    = edges_for(RES);
   localparam int HALF = DIV / 2;
   localparam int LEAD = N - RES;
   localparam int MASK = (1 << RES) - 1;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, alt_mode = 1'b1, fix_ch = 1'b0, miso = 1'b0;
   logic cs_n, sclk, ch_sel, out_valid, out_ch;
   logic [W-1:0] out_data;

   always #5 clk = ~clk;

   adc_dual_seq #(.RES_BITS(RES), .SCLK_DIV(DIV), .GAP_CYCLES(GAP), .WORD_W(W)) i_adc_dual_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .alt_mode(alt_mode), .fix_ch(fix_ch),
      .miso(miso), .cs_n(cs_n), .sclk(sclk), .ch_sel(ch_sel),
      .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic bit_for(input int r, input int c);
      if (r > LEAD && r <= N) return logic'((c >> (RES - r + LEAD)) & 1);
      return 1'b0;
   endfunction

   // converter model and checker, all on the falling system edge
   int  frames_done = 0, rises = 0, hc = 0, gapc = 0, code = 0;
   bit  gap_ok = 0, seen = 0, last_win = 0, samp = 0, expw;
   logic prev_cs = 1'b1, prev_sc = 1'b0, prev_ch = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         frames_done = 0; rises = 0; hc = 0; gapc = 0; gap_ok = 0; seen = 0;
         miso = 1'b0;
      end else begin
         bit cs_rise, cs_fall;
         cs_rise = (prev_cs == 1'b0) && (cs_n == 1'b1);
         cs_fall = (prev_cs == 1'b1) && (cs_n == 1'b0);
         if (ch_sel != prev_ch)
            chk(!cs_n && prev_sc && !sclk && rises == 1, "R4", rises, 1);
         if (!cs_n && !cs_fall) begin
            if (sclk != prev_sc) begin
               chk(hc == HALF - 1, "R2", hc + 1, HALF);
               hc = 0;
               if (sclk) rises++;
               else begin
                  if (rises == 1) begin
                     expw = alt_mode ? (seen ? !last_win : 1'b0) : fix_ch;
                     chk(ch_sel == expw, alt_mode ? "R5" : "R6", int'(ch_sel), int'(expw));
                     last_win = expw;
                     seen = 1;
                  end
                  miso = bit_for(rises + 1, code);
               end
            end else hc++;
         end
         if (cs_fall) begin
            chk(!sclk, "R2", int'(sclk), 0);
            if (gap_ok && frames_done > 0) chk(gapc == GAP, "R11", gapc, GAP);
            rises = 0; hc = 0; samp = ch_sel;
            code = int'($urandom) & MASK;
            miso = bit_for(1, code);
         end
         if (cs_rise) begin
            chk(rises == N, "R3", rises, N);
            chk(hc == HALF - 1 && !sclk, "R3", hc + 1, HALF);
            chk(out_valid == (frames_done > 0), "R9", int'(out_valid), int'(frames_done > 0));
            if (out_valid) begin
               chk(out_data == W'(code), "R7", int'(out_data), code);
               chk(out_ch == samp, "R8", int'(out_ch), int'(samp));
            end
            frames_done++;
            gapc = 0; gap_ok = 1;
         end else if (out_valid) chk(1'b0, "R10", 1, 0);
         if (cs_n) begin
            gapc++;
            if (!start) gap_ok = 0;
            if (sclk) chk(1'b0, "R2", 1, 0);
         end
      end
      prev_cs = cs_n; prev_sc = sclk; prev_ch = ch_sel;
   end

   task automatic run_frames(input int k);
      int target;
      target = frames_done + k;
      while (frames_done < target) @(negedge clk);
   endtask

   task automatic set_mode(input bit a, input bit f);
      @(posedge clk); #1;
      alt_mode = a; fix_ch = f;
   endtask

   task automatic check_reset_state();
      chk(cs_n == 1'b1, "R1", int'(cs_n), 1);
      chk(sclk == 1'b0, "R1", int'(sclk), 0);
      chk(ch_sel == 1'b0, "R1", int'(ch_sel), 0);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
   endtask

   initial begin
      int fd;
      bit stayed;
      void'($urandom(32'd2718));
      repeat (4) @(negedge clk);
      check_reset_state();
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check_reset_state();
      chk(cs_n == 1'b1, "R11", int'(cs_n), 1);   // start low: no frame

      @(posedge clk); #1 start = 1'b1;
      run_frames(8);                              // alternating from reset
      set_mode(1'b0, 1'b0); run_frames(3);        // fixed pair 0
      set_mode(1'b0, 1'b1); run_frames(3);        // fixed pair 1
      for (int i = 0; i < 30; i++) begin          // random mode mixes
         set_mode(bit'($urandom % 2), bit'($urandom % 2));
         run_frames(1 + int'($urandom % 3));
      end

      // R12: clear start mid-frame
      set_mode(1'b1, 1'b0);
      while (!(rises >= 5 && !cs_n)) @(negedge clk);
      @(posedge clk); #1 start = 1'b0;
      fd = frames_done;
      while (frames_done < fd + 1) @(negedge clk);
      stayed = 1;
      repeat (40) begin
         @(negedge clk);
         if (!cs_n) stayed = 0;
      end
      chk(stayed, "R12", int'(stayed), 1);
      chk(frames_done == fd + 1, "R12", frames_done, fd + 1);

      @(posedge clk); #1 start = 1'b1;
      run_frames(4);

      // reset in the middle of a frame, then first-frame rule again
      while (!(rises >= 3 && !cs_n)) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_reset_state();
      @(posedge clk); #1 rst_n = 1'b1;
      run_frames(4);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", frames_done, -1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule